// File: doc/BRIEF.md
# Legacy display range transaction router

This block sits on the CPU side of a host bridge and decides where each CPU-initiated transaction goes. A transaction either stays on the internal backbone or goes to one of several PCI Express graphics ports. Each request carries a type (memory or I/O), an address and per-byte lane enables. Each port supplies its bridge VGA enable, its I/O base/limit window and the memory-access and I/O-access enables from its command register. The block holds a monochrome-adapter-present bit for each port, and one such bit for the group of non-graphics devices. It also holds a DRAM memory-hole enable.

The main work is settling the overlap between the monochrome (MDA) legacy ranges and the VGA legacy ranges. The I/O decode uses only the low ten address bits, so ISA aliases match the same way as the base ports. A multi-byte I/O reference is judged as one unit: one MDA byte in it is enough to keep the whole reference away from a port that may not take MDA traffic. When several ports would claim a request, the lowest-numbered port wins. The decision is registered: it comes out one cycle after the request strobe as a one-hot port select, or a backbone flag.

Top module: `legacy_route_top`

## Requirements
- R1: After reset: `dec_valid`, `dec_port`, `dec_backbone`, `dec_hole` and `cfg_err` are 0. `cfg_rdata` reads with only the non-graphics MDA bit set (bit NPORT+1 = 1). Every port MDA bit (bits NPORT-1:0) and the hole enable (bit NPORT) read 0.
- R2: For a request strobed on `req_valid` at clock edge k, `dec_valid` is high after edge k and low after an edge with no request. While `dec_valid` is high, exactly one of the `dec_port` bits and `dec_backbone` is set. The decision fields hold their value between requests.
- R3: A memory request at 0x0B0000..0x0B7FFF (MDA memory) goes to a port only when that port has VGA enable = 1 and MDA bit = 0. A memory request elsewhere in 0x0A0000..0x0BFFFF goes to a port when its VGA enable = 1, whatever its MDA bit. All other memory addresses stay on the backbone.
- R4: I/O bytes 0x3B4, 0x3B5, 0x3B8, 0x3B9 and 0x3BA are MDA bytes, compared on address bits 9:0 only, so aliases match. An I/O request with any enabled MDA byte goes to a port only when that port has VGA enable = 1 and MDA bit = 0. This holds even when the request also has enabled VGA bytes.
- R5: An I/O request whose enabled bytes are all VGA bytes goes to any port with VGA enable = 1, whatever its MDA bit. VGA bytes are 0x3B0..0x3BB and 0x3C0..0x3DF minus the MDA bytes, on bits 9:0.
- R6: An I/O request with any enabled byte in 0x3BC..0x3BF (bits 9:0) goes to a port only when the port has VGA enable = 1 and MDA bit = 0, and its dword address is inside the port's I/O window. This rule takes precedence over R4 and R5.
- R7: Any other I/O request goes to a port when its dword address (bits 15:2, low bits 0) lies within `io_base`..`io_limit` inclusive. An I/O request with all byte enables 0 stays on the backbone.
- R8: A port takes a memory request only while its `mem_en` bit is 1, and an I/O request only while its `io_en` bit is 1.
- R9: A port with VGA enable = 0 and MDA bit = 1 claims nothing. `cfg_err` rises one cycle after such a combination is present and stays high until reset.
- R10: When several ports would claim a request, only the lowest-numbered one is selected.
- R11: With the hole enable = 1, a memory request at 0xF00000..0xFFFFFF stays on the backbone with `dec_hole` = 1. With the hole enable = 0, or outside that range, `dec_hole` = 0.
- R12: `cfg_we` loads `cfg_wdata` into the configuration register, laid out as in R1. A request in the same cycle is still decoded with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | NPORT+2 | Write data: port MDA bits, hole enable, non-graphics MDA bit |
| cfg_rdata | output | NPORT+2 | Current configuration register |
| cfg_err | output | 1 | Sticky illegal-combination flag |
| vga_en | input | NPORT | Per-port bridge VGA enable |
| mem_en | input | NPORT | Per-port memory-access enable |
| io_en | input | NPORT | Per-port I/O-access enable |
| io_base | input | NPORT*IOW | Per-port I/O window base, port p at [p*IOW +: IOW] |
| io_limit | input | NPORT*IOW | Per-port I/O window limit (inclusive) |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | AW | Request address (dword-aligned for I/O lanes) |
| req_be | input | NBE | Byte-lane enables |
| dec_valid | output | 1 | Decision strobe, one cycle after the request |
| dec_port | output | NPORT | One-hot selected port |
| dec_backbone | output | 1 | Request stays on the backbone |
| dec_hole | output | 1 | Memory request fell in the enabled hole |

## Verification
A wrong configuration bit shows on the ports through `cfg_rdata` on the very next cycle, and through the next decision that touches the MDA, VGA or parallel-port ranges of that port. A wrong decode state, such as a lost lane flag or a wrong priority pick, appears in `dec_port` or `dec_backbone` on the cycle after the request that exercises it. The reference model is compared every clock, so the mismatch is reported within one cycle of the faulty request. A wrong sticky flag shows on `cfg_err` one cycle after the illegal setting, or as an early clear after the setting is fixed.

// File: rtl/legacy_route_pkg.sv
package legacy_route_pkg;

  localparam logic [31:0] MDA_MEM_LO = 32'h000B_0000;
  localparam logic [31:0] MDA_MEM_HI = 32'h000B_7FFF;
  localparam logic [31:0] VGA_MEM_LO = 32'h000A_0000;
  localparam logic [31:0] VGA_MEM_HI = 32'h000B_FFFF;
  localparam logic [31:0] HOLE_LO    = 32'h00F0_0000;
  localparam logic [31:0] HOLE_HI    = 32'h00FF_FFFF;

  typedef struct packed {
    logic any_byte;
    logic any_mda;
    logic any_par;
    logic any_vga;
  } io_class_t;

  typedef struct packed {
    logic mda_mem;
    logic vga_mem;
    logic hole;
  } mem_class_t;

  function automatic logic io_is_mda(input logic [9:0] a);
    return (a == 10'h3B4) || (a == 10'h3B5) || (a == 10'h3B8) ||
           (a == 10'h3B9) || (a == 10'h3BA);
  endfunction

  function automatic logic io_is_par(input logic [9:0] a);
    return (a >= 10'h3BC) && (a <= 10'h3BF);
  endfunction

  function automatic logic io_is_vga(input logic [9:0] a);
    return ((a >= 10'h3B0) && (a <= 10'h3BB)) ||
           ((a >= 10'h3C0) && (a <= 10'h3DF));
  endfunction

endpackage

// File: rtl/lrt_classify.sv
module lrt_classify
  import legacy_route_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IOW = 16,
  parameter int NBE = 4
) (
  input  logic               req_is_io,
  input  logic [AW-1:0]      req_addr,
  input  logic [NBE-1:0]     req_be,
  input  logic               hole_en,
  output io_class_t          ioc,
  output mem_class_t         mc,
  output logic [IOW-1:0]     io_dw_addr
);
  localparam int LB = $clog2(NBE);

  logic [NBE-1:0] lane_mda, lane_par, lane_vga;

  for (genvar l = 0; l < NBE; l++) begin : g_lane
    logic [9:0] lane_a;
    assign lane_a      = {req_addr[9:LB], LB'(l)};
    assign lane_mda[l] = req_be[l] & io_is_mda(lane_a);
    assign lane_par[l] = req_be[l] & io_is_par(lane_a);
    assign lane_vga[l] = req_be[l] & io_is_vga(lane_a);
  end

  always_comb begin
    ioc.any_byte = |req_be;
    ioc.any_mda  = |lane_mda;
    ioc.any_par  = |lane_par;
    ioc.any_vga  = |lane_vga;
  end

  assign io_dw_addr = {req_addr[IOW-1:LB], {LB{1'b0}}};

  always_comb begin
    mc.mda_mem = (req_addr >= AW'(MDA_MEM_LO)) && (req_addr <= AW'(MDA_MEM_HI));
    mc.vga_mem = (req_addr >= AW'(VGA_MEM_LO)) && (req_addr <= AW'(VGA_MEM_HI));
    mc.hole    = hole_en && !req_is_io &&
                 (req_addr >= AW'(HOLE_LO)) && (req_addr <= AW'(HOLE_HI));
  end

endmodule

// File: rtl/lrt_cfg_regs.sv
module lrt_cfg_regs #(
  parameter int NPORT = 4,
  localparam int CW   = NPORT + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_wdata,
  input  logic [NPORT-1:0] vga_en,
  output logic [NPORT-1:0] mda,
  output logic             hole_en,
  output logic             ng_mda,
  output logic             cfg_err
);
  logic [NPORT-1:0] mda_nx;
  logic             hole_nx, ng_nx, err_nx;
  logic             bad_combo;

  assign bad_combo = |(mda & ~vga_en);

  always_comb begin
    mda_nx  = mda;
    hole_nx = hole_en;
    ng_nx   = ng_mda;
    if (cfg_we) begin
      mda_nx  = cfg_wdata[NPORT-1:0];
      hole_nx = cfg_wdata[NPORT];
      ng_nx   = cfg_wdata[NPORT+1];
    end
    err_nx = cfg_err | bad_combo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mda     <= '0;
      hole_en <= 1'b0;
      ng_mda  <= 1'b1;
      cfg_err <= 1'b0;
    end else begin
      mda     <= mda_nx;
      hole_en <= hole_nx;
      ng_mda  <= ng_nx;
      cfg_err <= err_nx;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R9
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mda & ~vga_en)) |=> cfg_err); // R9

endmodule

// File: rtl/lrt_port_claim.sv
module lrt_port_claim
  import legacy_route_pkg::*;
#(
  parameter int IOW = 16
) (
  input  logic           is_io,
  input  io_class_t      ioc,
  input  mem_class_t     mc,
  input  logic [IOW-1:0] io_dw_addr,
  input  logic           vga,
  input  logic           mda,
  input  logic           mem_ok_en,
  input  logic           io_ok_en,
  input  logic [IOW-1:0] win_lo,
  input  logic [IOW-1:0] win_hi,
  output logic           claim
);
  logic in_win, illegal, io_ok, mem_ok, mda_owner;

  assign in_win    = (io_dw_addr >= win_lo) && (io_dw_addr <= win_hi);
  assign illegal   = mda & ~vga;
  assign mda_owner = vga & ~mda;

  always_comb begin
    if (ioc.any_par)      io_ok = mda_owner & in_win;
    else if (ioc.any_mda) io_ok = mda_owner;
    else if (ioc.any_vga) io_ok = vga;
    else                  io_ok = in_win;
    io_ok = io_ok & io_ok_en & ioc.any_byte;

    if (mc.mda_mem)       mem_ok = mda_owner;
    else if (mc.vga_mem)  mem_ok = vga;
    else                  mem_ok = 1'b0;
    mem_ok = mem_ok & mem_ok_en & ~mc.hole;

    claim = ~illegal & (is_io ? io_ok : mem_ok);
  end

endmodule

// File: rtl/lrt_pick_reg.sv
module lrt_pick_reg #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [NPORT-1:0] claim,
  input  logic             hole,
  output logic             dec_valid,
  output logic [NPORT-1:0] dec_port,
  output logic             dec_backbone,
  output logic             dec_hole
);
  logic [NPORT-1:0] grant, port_nx;
  logic             bb_nx, hole_nx;

  assign grant = claim & (~claim + NPORT'(1));

  always_comb begin
    port_nx = dec_port;
    bb_nx   = dec_backbone;
    hole_nx = dec_hole;
    if (req_valid) begin
      port_nx = grant;
      bb_nx   = ~|claim;
      hole_nx = hole;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_port     <= '0;
      dec_backbone <= 1'b0;
      dec_hole     <= 1'b0;
    end else begin
      dec_valid    <= req_valid;
      dec_port     <= port_nx;
      dec_backbone <= bb_nx;
      dec_hole     <= hole_nx;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($countones({dec_port, dec_backbone}) == 1)); // R2
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dec_valid); // R2
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && claim[0]) |=> dec_port[0]); // R10
  AST_HOLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_hole) |-> dec_backbone); // R11

endmodule

// File: rtl/legacy_route_top.sv
module legacy_route_top
  import legacy_route_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int AW    = 32,
  parameter int IOW   = 16,
  parameter int NBE   = 4,
  localparam int CW   = NPORT + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CW-1:0]        cfg_wdata,
  output logic [CW-1:0]        cfg_rdata,
  output logic                 cfg_err,
  input  logic [NPORT-1:0]     vga_en,
  input  logic [NPORT-1:0]     mem_en,
  input  logic [NPORT-1:0]     io_en,
  input  logic [NPORT*IOW-1:0] io_base,
  input  logic [NPORT*IOW-1:0] io_limit,
  input  logic                 req_valid,
  input  logic                 req_is_io,
  input  logic [AW-1:0]        req_addr,
  input  logic [NBE-1:0]       req_be,
  output logic                 dec_valid,
  output logic [NPORT-1:0]     dec_port,
  output logic                 dec_backbone,
  output logic                 dec_hole
);
  io_class_t        ioc;
  mem_class_t       mc;
  logic [IOW-1:0]   io_dw_addr;
  logic [NPORT-1:0] mda, claim;
  logic             hole_en, ng_mda;

  assign cfg_rdata = {ng_mda, hole_en, mda};

  lrt_cfg_regs #(.NPORT(NPORT)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .vga_en   (vga_en),
    .mda      (mda),
    .hole_en  (hole_en),
    .ng_mda   (ng_mda),
    .cfg_err  (cfg_err)
  );

  lrt_classify #(.AW(AW), .IOW(IOW), .NBE(NBE)) i_cls (
    .req_is_io (req_is_io),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .hole_en   (hole_en),
    .ioc       (ioc),
    .mc        (mc),
    .io_dw_addr(io_dw_addr)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    lrt_port_claim #(.IOW(IOW)) i_claim (
      .is_io     (req_is_io),
      .ioc       (ioc),
      .mc        (mc),
      .io_dw_addr(io_dw_addr),
      .vga       (vga_en[p]),
      .mda       (mda[p]),
      .mem_ok_en (mem_en[p]),
      .io_ok_en  (io_en[p]),
      .win_lo    (io_base[p*IOW +: IOW]),
      .win_hi    (io_limit[p*IOW +: IOW]),
      .claim     (claim[p])
    );

    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mda[p] && !vga_en[p]) |-> !claim[p]); // R9
    AST_MDA_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_io && mda[p] && ioc.any_mda) |-> !claim[p]); // R4
    AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_io && !io_en[p]) |-> !claim[p]); // R8
    AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_io && !mem_en[p]) |-> !claim[p]); // R8
  end

  lrt_pick_reg #(.NPORT(NPORT)) i_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .claim       (claim),
    .hole        (mc.hole),
    .dec_valid   (dec_valid),
    .dec_port    (dec_port),
    .dec_backbone(dec_backbone),
    .dec_hole    (dec_hole)
  );

endmodule

// File: tb/test_legacy_route_top.sv
`timescale 1ns/1ps
module test_legacy_route_top;
  localparam int NP = 4;
  localparam int CW = NP + 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cfg_we;
  logic [CW-1:0]  cfg_wdata;
  logic [CW-1:0]  cfg_rdata;
  logic           cfg_err;
  logic [NP-1:0]  vga_en, mem_en, io_en;
  logic [NP*16-1:0] io_base, io_limit;
  logic           req_valid, req_is_io;
  logic [31:0]    req_addr;
  logic [3:0]     req_be;
  logic           dec_valid, dec_backbone, dec_hole;
  logic [NP-1:0]  dec_port;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  string cur_tag = "R2";

  always #4 clk = ~clk;

  legacy_route_top i_legacy_route_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .vga_en(vga_en),
    .mem_en(mem_en), .io_en(io_en), .io_base(io_base), .io_limit(io_limit),
    .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
    .req_be(req_be), .dec_valid(dec_valid), .dec_port(dec_port),
    .dec_backbone(dec_backbone), .dec_hole(dec_hole)
  );

  // ---------------- reference model ----------------
  logic [NP-1:0] m_mda;
  bit   m_hole_en, m_ng, m_err;
  bit   e_valid, e_bb, e_hole;
  logic [NP-1:0] e_port;
  string e_tag;

  function automatic bit m_claim(int p, bit io, logic [31:0] a, logic [3:0] be);
    bit v = vga_en[p];
    bit m = m_mda[p];
    bit mda_b = 0, par_b = 0, vga_b = 0, in_win;
    int lo = int'(io_base[p*16 +: 16]);
    int hi = int'(io_limit[p*16 +: 16]);
    int dw = int'(a & 32'h0000_FFFC);
    if (!v && m) return 0;
    if (!io) begin
      if (!mem_en[p]) return 0;
      if (a >= 32'hB0000 && a <= 32'hB7FFF) return v && !m;
      if (a >= 32'hA0000 && a <= 32'hBFFFF) return v;
      return 0;
    end
    if (!io_en[p] || be == 4'b0) return 0;
    for (int i = 0; i < 4; i++) begin
      if (be[i]) begin
        int b = int'(a & 32'h3FC) + i;
        if (b == 'h3B4 || b == 'h3B5 || b == 'h3B8 || b == 'h3B9 || b == 'h3BA) mda_b = 1;
        if (b >= 'h3BC && b <= 'h3BF) par_b = 1;
        if ((b >= 'h3B0 && b <= 'h3BB) || (b >= 'h3C0 && b <= 'h3DF)) vga_b = 1;
      end
    end
    in_win = (dw >= lo) && (dw <= hi);
    if (par_b) return v && !m && in_win;
    if (mda_b) return v && !m;
    if (vga_b) return v;
    return in_win;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mda = '0; m_hole_en = 0; m_ng = 1; m_err = 0;
      e_valid = 0; e_port = '0; e_bb = 0; e_hole = 0; e_tag = "R1";
    end else begin
      bit hole_hit;
      e_valid = req_valid;
      if (req_valid) begin
        e_tag = cur_tag;
        hole_hit = !req_is_io && m_hole_en && req_addr >= 32'hF00000 && req_addr <= 32'hFFFFFF;
        e_port = '0;
        e_hole = hole_hit;
        e_bb   = 1;
        if (!hole_hit) begin
          for (int p = 0; p < NP; p++) begin
            if (e_bb && m_claim(p, req_is_io, req_addr, req_be)) begin
              e_port[p] = 1'b1;
              e_bb = 0;
            end
          end
        end
      end
      if ((m_mda & ~vga_en) != '0) m_err = 1;
      if (cfg_we) begin
        m_mda     = cfg_wdata[NP-1:0];
        m_hole_en = cfg_wdata[NP];
        m_ng      = cfg_wdata[NP+1];
      end
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2", "dec_valid", dec_valid, e_valid);
      check(e_tag, "dec_port", dec_port, e_port);
      check(e_tag, "dec_backbone", dec_backbone, e_bb);
      check("R11", "dec_hole", dec_hole, e_hole);
      check("R12", "cfg_rdata", cfg_rdata, {m_ng, m_hole_en, m_mda});
      check("R9", "cfg_err", cfg_err, m_err);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(bit io, logic [31:0] a, logic [3:0] be);
    req_valid = 1; req_is_io = io; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic cfg(logic [CW-1:0] d);
    cfg_we = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic set_win(int p, logic [15:0] lo, logic [15:0] hi);
    io_base[p*16 +: 16] = lo;
    io_limit[p*16 +: 16] = hi;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_wdata = '0; vga_en = '0; mem_en = '0; io_en = '0;
    io_base = '1; io_limit = '0; req_valid = 0; req_is_io = 0; req_addr = '0; req_be = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state seen directly at the ports
    check("R1", "reset dec_valid", dec_valid, 0);
    check("R1", "reset cfg_rdata", cfg_rdata, 6'h20);
    check("R1", "reset cfg_err", cfg_err, 0);
    check("R1", "reset dec_port", dec_port, 0);

    mem_en = '1; io_en = '1; vga_en = 4'b0001;
    // R3: MDA memory and VGA memory
    cur_tag = "R3";
    send(0, 32'h000B0000, 4'hF);
    send(0, 32'h000B7FFC, 4'hF);
    cfg(6'h21);
    send(0, 32'h000B0000, 4'hF);
    send(0, 32'h000A0000, 4'hF);
    send(0, 32'h000B8000, 4'hF);
    send(0, 32'h000C0000, 4'hF);
    send(0, 32'h010B0000, 4'hF);

    // R4: MDA I/O bytes, aliases, pinning of mixed references
    cur_tag = "R4";
    send(1, 32'h3B4, 4'hF);
    send(1, 32'h3B4, 4'h1);
    send(1, 32'h3B8, 4'h4);
    cfg(6'h20);
    send(1, 32'h7B4, 4'h1);
    send(1, 32'hFFB8, 4'h2);
    send(1, 32'h3B4, 4'hF);
    // R5: VGA-only bytes claimed whatever the MDA bit
    cur_tag = "R5";
    cfg(6'h21);
    send(1, 32'h3B4, 4'hC);
    send(1, 32'h3C0, 4'hF);
    send(1, 32'h3DC, 4'h8);
    send(1, 32'h3E0, 4'h1);

    // R6: 0x3BC..0x3BF needs MDA bit clear and window hit
    cur_tag = "R6";
    cfg(6'h20);
    set_win(0, 16'h03B0, 16'h03BF);
    send(1, 32'h3BC, 4'h1);
    send(1, 32'h3BC, 4'h8);
    set_win(0, 16'h1000, 16'h1FFF);
    send(1, 32'h3BC, 4'h1);
    set_win(0, 16'h03B0, 16'h03BF);
    cfg(6'h21);
    send(1, 32'h3BC, 4'h1);
    cfg(6'h20);

    // R7: plain window forwarding and empty byte enables
    cur_tag = "R7";
    vga_en = 4'b0000;
    set_win(1, 16'h2000, 16'h2FFF);
    send(1, 32'h2004, 4'h1);
    send(1, 32'h2FFC, 4'h8);
    send(1, 32'h3000, 4'h1);
    send(1, 32'h2004, 4'h0);
    send(1, 32'h3C0, 4'h1);

    // R8: command enables gate forwarding
    cur_tag = "R8";
    vga_en = 4'b0001;
    io_en = 4'b1110;
    send(1, 32'h3C0, 4'h1);
    io_en = '1; mem_en = 4'b1110;
    send(0, 32'h000A0000, 4'hF);
    mem_en = '1;
    send(0, 32'h000A0000, 4'hF);

    // R9: illegal combination claims nothing, sticky flag
    cur_tag = "R9";
    vga_en = 4'b0000;
    set_win(1, 16'h0000, 16'h0000);
    set_win(2, 16'h2000, 16'h2FFF);
    send(1, 32'h2004, 4'h1);
    cfg(6'h24);
    send(1, 32'h2004, 4'h1);
    @(negedge clk);
    check("R9", "err raised", cfg_err, 1);
    cfg(6'h20);
    repeat (2) @(negedge clk);
    check("R9", "err sticky", cfg_err, 1);
    send(1, 32'h2004, 4'h1);
    set_win(2, 16'hFFFF, 16'h0000);

    // R10: lowest-numbered claimant wins
    cur_tag = "R10";
    vga_en = 4'b1010;
    send(1, 32'h3C4, 4'h1);
    send(0, 32'h000A1000, 4'hF);
    vga_en = 4'b1011;
    send(1, 32'h3C4, 4'h1);
    io_en = 4'b0111;
    vga_en = 4'b1000;
    send(1, 32'h3C4, 4'h1);
    io_en = '1;

    // R11: memory hole
    cur_tag = "R11";
    cfg(6'h30);
    send(0, 32'h00F00000, 4'hF);
    send(0, 32'h00FFFFFC, 4'hF);
    send(0, 32'h00EFFFFC, 4'hF);
    send(0, 32'h01000000, 4'hF);
    send(1, 32'h00F00000, 4'hF);
    cfg(6'h20);
    send(0, 32'h00F00000, 4'hF);

    // R12: a write in the same cycle as a request leaves that request on the old value
    cur_tag = "R12";
    vga_en = 4'b0001;
    cfg_we = 1; cfg_wdata = 6'h21;
    send(1, 32'h3B4, 4'h1);
    cfg_we = 0;
    send(1, 32'h3B4, 4'h1);
    check("R12", "write visible", cfg_rdata, 6'h21);

    // R2: back-to-back requests, then idle
    cur_tag = "R2";
    req_valid = 1; req_is_io = 1; req_addr = 32'h3C0; req_be = 4'h1;
    @(negedge clk);
    req_addr = 32'h3B4;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    check("R2", "idle hold", dec_valid, 0);

    finish_run();
  end

endmodule